// File: doc/BRIEF.md
# Spectral Channel Aggregator

This block lowers the spectral resolution of correlator output after the products have been accumulated. Each product arrives as a spectrum of complex values, one beat per frequency bin, with the bin index counting up from 0. The block adds together groups of N neighbouring bins and emits one complex sum per group. It also emits the index of the coarser output bin. N is a power of two from 2 to 64 and is chosen at run time. A setting of 1 lets the data through unchanged.

Native bins are 15.625 kHz wide, so with factor N each output bin covers N times that width. A 1024-bin spectrum shrinks to 1024/N outputs. The sums are wide enough that the largest factor cannot overflow. A new factor takes effect only when a new spectrum starts. Groups never span a group boundary or two products, because bin 0 always starts a new group.

Top module: `chan_agg`

## Requirements
- R1: After reset `out_valid_o` is low and the active factor is 1 (pass-through). Without a bin-0 beat, a factor code on `factor_i` does not change this.
- R2: `factor_i` holds log2(N), so codes 0..6 select N = 1, 2, 4, 8, 16, 32 and 64. Code 7 behaves like code 6.
- R3: With N = 1, each input beat appears one cycle later with the same bin index and with the real and imaginary parts sign-extended.
- R4: With N > 1, a group is the N bins whose index differs only in its low log2(N) bits. The sum of the group appears one cycle after the beat whose low log2(N) bits are all ones. `out_valid_o` stays low after every other beat.
- R5: `out_bin_o` equals the input bin index of the group shifted right by log2(N).
- R6: Both accumulators are 6 bits wider than the input. A group of 64 full-scale negative or full-scale positive values is summed exactly.
- R7: The factor code is sampled only on a valid beat with bin index 0. Changes on `factor_i` at any other beat have no effect on grouping.
- R8: A bin-0 beat that arrives while a group is still open drops the partial sum and starts a new group. The dropped bins never reach the output.
- R9: Cycles with `in_valid_i` low neither change the running sums nor produce output. `out_valid_o` is low in the cycle after every such cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| factor_i | input | 3 | log2 of the aggregation factor, sampled at bin 0 |
| in_valid_i | input | 1 | input beat valid |
| in_bin_i | input | 10 | input bin index |
| in_re_i | input | 24 | real part, signed |
| in_im_i | input | 24 | imaginary part, signed |
| out_valid_o | output | 1 | output beat valid |
| out_bin_o | output | 10 | output bin index |
| out_re_o | output | 30 | summed real part, signed |
| out_im_o | output | 30 | summed imaginary part, signed |

## Verification
The assertions assume that each product's bins arrive in rising order starting at 0. They also assume that every group is complete unless a new bin 0 cuts it short. The stimulus only sends runs that start at bin 0 and count up with no gaps. The one exception is the deliberate truncation, which is always followed by a bin 0. Idle cycles are placed between beats and never replace one.

// File: rtl/chan_agg_pkg.sv
package chan_agg_pkg;
  localparam int MAX_K_DEF = 6;

  // limit a requested log2 factor to the supported maximum
  function automatic logic [2:0] clamp_k(input logic [2:0] code, input int max_k);
    return (int'(code) > max_k) ? 3'(max_k) : code;
  endfunction
endpackage

// File: rtl/agg_factor_ctl.sv
module agg_factor_ctl #(
  parameter int BIN_W = 10,
  parameter int MAX_K = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [BIN_W-1:0] bin_i,
  input  logic [2:0]       code_i,
  output logic [2:0]       act_k_o,
  output logic [2:0]       eff_k_o,
  output logic             first_o,
  output logic             last_o
);
  import chan_agg_pkg::*;

  logic [2:0]       act_k;
  logic [2:0]       eff_k;
  logic             bin_zero;
  logic [BIN_W-1:0] mask;
  logic [BIN_W-1:0] low;

  assign bin_zero = (bin_i == '0);
  assign eff_k    = bin_zero ? clamp_k(code_i, MAX_K) : act_k;
  assign mask     = ~({BIN_W{1'b1}} << eff_k);
  assign low      = bin_i & mask;
  assign first_o  = (low == '0);
  assign last_o   = (low == mask);
  assign eff_k_o  = eff_k;
  assign act_k_o  = act_k;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_k <= '0;
    else if (valid_i && bin_zero) act_k <= eff_k;
  end
endmodule

// File: rtl/agg_lane.sv
module agg_lane #(
  parameter int IN_W  = 24,
  parameter int OUT_W = 30
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic                    first_i,
  input  logic                    last_i,
  input  logic signed [IN_W-1:0]  d_i,
  output logic signed [OUT_W-1:0] q_o
);
  logic signed [OUT_W-1:0] acc;
  logic signed [OUT_W-1:0] d_ext;
  logic signed [OUT_W-1:0] sum_nxt;

  assign d_ext   = OUT_W'(d_i);
  // first bin of a group reloads, dropping any stale partial sum
  assign sum_nxt = first_i ? d_ext : (acc + d_ext);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc <= '0;
      q_o <= '0;
    end else if (valid_i) begin
      acc <= sum_nxt;
      if (last_i) q_o <= sum_nxt;
    end
  end
endmodule

// File: rtl/agg_out_ctl.sv
module agg_out_ctl #(
  parameter int BIN_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             last_i,
  input  logic [BIN_W-1:0] bin_i,
  input  logic [2:0]       eff_k_i,
  output logic             valid_o,
  output logic [BIN_W-1:0] bin_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      bin_o   <= '0;
    end else begin
      valid_o <= valid_i && last_i;
      if (valid_i && last_i) bin_o <= bin_i >> eff_k_i;
    end
  end
endmodule

// File: rtl/chan_agg.sv
module chan_agg #(
  parameter int IN_W     = 24,
  parameter int NUM_BINS = 1024,
  parameter int MAX_K    = chan_agg_pkg::MAX_K_DEF,
  parameter int BIN_W    = $clog2(NUM_BINS),
  parameter int OUT_W    = IN_W + MAX_K
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [2:0]              factor_i,
  input  logic                    in_valid_i,
  input  logic [BIN_W-1:0]        in_bin_i,
  input  logic signed [IN_W-1:0]  in_re_i,
  input  logic signed [IN_W-1:0]  in_im_i,
  output logic                    out_valid_o,
  output logic [BIN_W-1:0]        out_bin_o,
  output logic signed [OUT_W-1:0] out_re_o,
  output logic signed [OUT_W-1:0] out_im_o
);
  localparam int LANES = 2;

  logic [2:0] act_k;
  logic [2:0] eff_k;
  logic       grp_first;
  logic       grp_last;

  logic signed [IN_W-1:0]  lane_d [LANES];
  logic signed [OUT_W-1:0] lane_q [LANES];

  assign lane_d[0] = in_re_i;
  assign lane_d[1] = in_im_i;
  assign out_re_o  = lane_q[0];
  assign out_im_o  = lane_q[1];

  agg_factor_ctl #(.BIN_W(BIN_W), .MAX_K(MAX_K)) u_ctl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (in_valid_i),
    .bin_i   (in_bin_i),
    .code_i  (factor_i),
    .act_k_o (act_k),
    .eff_k_o (eff_k),
    .first_o (grp_first),
    .last_o  (grp_last)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    agg_lane #(.IN_W(IN_W), .OUT_W(OUT_W)) u_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .valid_i (in_valid_i),
      .first_i (grp_first),
      .last_i  (grp_last),
      .d_i     (lane_d[g]),
      .q_o     (lane_q[g])
    );
  end

  agg_out_ctl #(.BIN_W(BIN_W)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (in_valid_i),
    .last_i  (grp_last),
    .bin_i   (in_bin_i),
    .eff_k_i (eff_k),
    .valid_o (out_valid_o),
    .bin_o   (out_bin_o)
  );
endmodule

// File: rtl/chan_agg_chk.sv
module chan_agg_chk #(
  parameter int IN_W     = 24,
  parameter int NUM_BINS = 1024,
  parameter int MAX_K    = 6,
  parameter int BIN_W    = 10,
  parameter int OUT_W    = 30
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    in_valid_i,
  input logic [BIN_W-1:0]        in_bin_i,
  input logic signed [IN_W-1:0]  in_re_i,
  input logic signed [IN_W-1:0]  in_im_i,
  input logic                    out_valid_o,
  input logic [BIN_W-1:0]        out_bin_o,
  input logic signed [OUT_W-1:0] out_re_o,
  input logic signed [OUT_W-1:0] out_im_o,
  input logic [2:0]              act_k,
  input logic [2:0]              eff_k
);
  logic [BIN_W-1:0] chk_mask;
  assign chk_mask = ~({BIN_W{1'b1}} << eff_k);

  assert_idle_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);

  assert_pass_through_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && eff_k == 3'd0) |=>
      (out_valid_o && out_re_o == $past(in_re_i) && out_im_o == $past(in_im_i)
       && out_bin_o == $past(in_bin_i)));

  assert_mid_group_silent_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && (in_bin_i & chk_mask) != chk_mask) |=> !out_valid_o);

  assert_bin_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (int'(out_bin_o) < (NUM_BINS >> act_k)));

  assert_factor_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_valid_i && in_bin_i == '0) |=> $stable(act_k));

  assert_code_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(act_k) <= MAX_K);
endmodule

bind chan_agg chan_agg_chk #(
  .IN_W(IN_W), .NUM_BINS(NUM_BINS), .MAX_K(MAX_K), .BIN_W(BIN_W), .OUT_W(OUT_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_bin_i    (in_bin_i),
  .in_re_i     (in_re_i),
  .in_im_i     (in_im_i),
  .out_valid_o (out_valid_o),
  .out_bin_o   (out_bin_o),
  .out_re_o    (out_re_o),
  .out_im_o    (out_im_o),
  .act_k       (act_k),
  .eff_k       (eff_k)
);

// File: tb/sim_chan_agg.sv
module sim_chan_agg;
  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [2:0]         factor = '0;
  logic               in_valid = 1'b0;
  logic [9:0]         in_bin = '0;
  logic signed [23:0] in_re = '0;
  logic signed [23:0] in_im = '0;
  logic               out_valid;
  logic [9:0]         out_bin;
  logic signed [29:0] out_re;
  logic signed [29:0] out_im;

  int n_total = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // bench model state
  int     exp_k = 0;
  longint acc_re = 0;
  longint acc_im = 0;

  always #5 clk = ~clk;

  chan_agg u0 (
    .clk_i(clk), .rst_ni(rst_n), .factor_i(factor), .in_valid_i(in_valid),
    .in_bin_i(in_bin), .in_re_i(in_re), .in_im_i(in_im),
    .out_valid_o(out_valid), .out_bin_o(out_bin), .out_re_o(out_re), .out_im_o(out_im)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int pat_re(int bin, int seed);
    return ((bin * 131 + seed * 7) % 4001) - 2000;
  endfunction

  function automatic int pat_im(int bin, int seed);
    return seed * 5 - bin * 3;
  endfunction

  // one valid beat, model update, and check one cycle later
  task automatic beat(input int bin, input int re, input int im, input string tag);
    int  mask;
    bit  last;
    in_valid = 1'b1;
    in_bin   = 10'(bin);
    in_re    = 24'(re);
    in_im    = 24'(im);
    if (bin == 0) exp_k = (int'(factor) > 6) ? 6 : int'(factor);
    mask = (1 << exp_k) - 1;
    if ((bin & mask) == 0) begin
      acc_re = re; acc_im = im;
    end else begin
      acc_re += re; acc_im += im;
    end
    last = ((bin & mask) == mask);
    @(posedge clk); #1;
    in_valid = 1'b0;
    chk(out_valid == last, tag, "out_valid", longint'(out_valid), longint'(last));
    if (last && out_valid) begin
      chk(longint'(out_re) == acc_re, tag, "out_re", longint'(out_re), acc_re);
      chk(longint'(out_im) == acc_im, tag, "out_im", longint'(out_im), acc_im);
      chk(int'(out_bin) == (bin >> exp_k), tag, "out_bin",
          longint'(out_bin), longint'(bin >> exp_k));
    end
  endtask

  task automatic idle(input string tag);
    in_valid = 1'b0;
    @(posedge clk); #1;
    chk(out_valid == 1'b0, tag, "out_valid idle", longint'(out_valid), 0);
  endtask

  task automatic t_reset;
    chk(out_valid == 1'b0, "R1", "out_valid in reset", longint'(out_valid), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", longint'(out_valid), 0);
    // no bin 0 yet: code 3 must not take effect, beat passes through
    factor = 3'd3;
    exp_k  = 0;
    beat(5, 77, -9, "R1");
    factor = 3'd0;
  endtask

  task automatic t_pass;
    factor = 3'd0;
    for (int b = 0; b < 8; b++) beat(b, pat_re(b, 3), pat_im(b, 3), "R3");
    beat(0, -8388608, 8388607, "R3");
  endtask

  task automatic t_factor(input int k, input string tag);
    factor = 3'(k);
    for (int b = 0; b < 128; b++) beat(b, pat_re(b, k), pat_im(b, k), tag);
  endtask

  task automatic t_extremes;
    factor = 3'd6;
    for (int b = 0; b < 64; b++) beat(b, -8388608, 8388607, "R6");
    for (int b = 64; b < 128; b++) beat(b, 8388607, -8388608, "R6");
  endtask

  task automatic t_ignored_change;
    factor = 3'd2;
    beat(0, pat_re(0, 9), pat_im(0, 9), "R7");
    factor = 3'd0;
    for (int b = 1; b < 16; b++) beat(b, pat_re(b, 9), pat_im(b, 9), "R7");
    factor = 3'd5;
    for (int b = 16; b < 24; b++) beat(b, pat_re(b, 9), pat_im(b, 9), "R7");
  endtask

  task automatic t_partial;
    factor = 3'd3;
    for (int b = 0; b < 5; b++) beat(b, 1000, 1000, "R8");
    for (int b = 0; b < 8; b++) beat(b, pat_re(b, 11), pat_im(b, 11), "R8");
  endtask

  task automatic t_idle;
    factor = 3'd1;
    for (int b = 0; b < 8; b++) begin
      beat(b, pat_re(b, 13), pat_im(b, 13), "R9");
      idle("R9");
      idle("R9");
    end
  endtask

  initial begin
    t_reset();
    t_pass();
    t_factor(1, "R4");
    t_factor(2, "R4");
    t_factor(3, "R5");
    t_factor(4, "R5");
    t_factor(5, "R4");
    t_factor(6, "R4");
    t_factor(7, "R2");
    t_extremes();
    t_ignored_change();
    t_partial();
    t_idle();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_total++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end
endmodule